// File: doc/BRIEF.md
# High-Address Latch and Chip-Select Decoder

This block sits on a processor bus that carries the high and low address bytes on the same pins at different times. A strobe marks the high byte. While the strobe is high the block follows the bus. On the falling edge of the strobe it holds six bits of the high byte. The lower four held bits go out as upper address lines. The upper two held bits pick one of four active-low chip selects.

The selects are gated after the latch by an active-low chip enable. In the gated build variant they are also gated by active-low read and write strobes, so that a memory with no output enable does not drive the data bus outside an access. Because this gating is not latched, a change on the enable or on the strobes reaches the selects at once, with no new address strobe. If the latch strobe is tied high, the block follows its inputs directly and suits a bus that is not multiplexed.

Top module: `hiaddr_latch_dec`

## Requirements
- R1: While `stb_i` is high and reset is released, `hi_addr_o` and the select decode follow `ma_i` with no clock.
- R2: `hi_addr_o` equals held bits `ma[3:0]`. It is unaffected by `ce_ni`, `rd_ni` and `wr_ni`.
- R3: When enabled, exactly one bit of `cs_no` is low. Its index is held bits `{ma[5],ma[4]}`: 0 drives `cs_no[0]` low, 1 drives `cs_no[1]`, 2 drives `cs_no[2]`, 3 drives `cs_no[3]`.
- R4: `ce_ni` high drives all of `cs_no` high, whatever the values of `stb_i` and `ma_i`.
- R5: With `GATE_MODE = GATE_CE_RW`, when `rd_ni` and `wr_ni` are both high, all of `cs_no` is high. When either of them is low, the selects follow `ce_ni`.
- R6: While `stb_i` is low, both outputs keep the address held at the last falling edge of `stb_i`, whatever `ma_i` does.
- R7: With `GATE_MODE = GATE_CE_ONLY`, `rd_ni` and `wr_ni` have no effect on any output.
- R8: While `rst_ni` is low, the held address is zero, `hi_addr_o` is zero and all of `cs_no` is high. After reset is released with `stb_i` low, the selects decode address zero.
- R9: A change of `ce_ni`, `rd_ni` or `wr_ni` while `stb_i` is low reaches `cs_no` at once and does not disturb the held address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_ni | input | 1 | Asynchronous reset, active low; clears the held address |
| stb_i | input | 1 | Latch strobe: high is transparent, the falling edge holds |
| ce_ni | input | 1 | Chip enable for the selects, active low |
| rd_ni | input | 1 | Memory read strobe, active low (used only in the gated variant) |
| wr_ni | input | 1 | Memory write strobe, active low (used only in the gated variant) |
| ma_i | input | HI_W+SEL_W (6) | Multiplexed address byte; `[3:0]` drive the upper address lines and `[5:4]` drive the select |
| hi_addr_o | output | HI_W (4) | Held upper address lines |
| cs_no | output | 2**SEL_W (4) | Decoded chip selects, active low |

## Verification
The hardest case to reach is the hold phase: the address on the bus has moved away from the held value while the enable and the strobes still change. A broken latch or a gate placed in front of the latch stays hidden unless both happen together. The stimulus strobes each of the 64 addresses in, drops the strobe, inverts every bus bit, and then steps through the enable and strobe combinations. It never raises the strobe again during these steps. A plain-variant instance runs on the same stimulus, so a single step shows whether the strobes matter.

// File: rtl/hiaddr_latch_dec_pkg.sv
`timescale 1ns/1ps
package hiaddr_latch_dec_pkg;
  typedef enum logic {
    GATE_CE_ONLY = 1'b0,
    GATE_CE_RW   = 1'b1
  } gate_mode_e;
endpackage

// File: rtl/had_latch.sv
`timescale 1ns/1ps
// Level-sensitive holding latch, transparent while en_i is high.
module had_latch #(
  parameter int unsigned W = 6
) (
  input  logic         rst_ni,
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  always_latch begin
    if (!rst_ni)   q_o <= '0;
    else if (en_i) q_o <= d_i;
  end
endmodule

// File: rtl/had_sel_decode.sv
`timescale 1ns/1ps
// Binary to one-hot, active high.
module had_sel_decode #(
  parameter int unsigned SEL_W  = 2,
  localparam int unsigned NUM_O = 1 << SEL_W
) (
  input  logic [SEL_W-1:0] sel_i,
  output logic [NUM_O-1:0] hit_o
);
  for (genvar i = 0; i < NUM_O; i++) begin : g_hit
    assign hit_o[i] = (sel_i == SEL_W'(i));
  end
endmodule

// File: rtl/had_cs_gate.sv
`timescale 1ns/1ps
// Gating applied after the latch; no storage in this path.
module had_cs_gate
  import hiaddr_latch_dec_pkg::*;
#(
  parameter int unsigned N         = 4,
  parameter gate_mode_e  GATE_MODE = GATE_CE_RW
) (
  input  logic         rst_ni,
  input  logic         ce_ni,
  input  logic         rd_ni,
  input  logic         wr_ni,
  input  logic [N-1:0] hit_i,
  output logic [N-1:0] cs_no
);
  logic strobe_ok;
  logic enable;

  if (GATE_MODE == GATE_CE_RW) begin : g_rw
    assign strobe_ok = ~(rd_ni & wr_ni);
  end else begin : g_ce_only
    logic unused_rw;
    assign unused_rw = rd_ni ^ wr_ni;
    assign strobe_ok = 1'b1;
  end

  assign enable = rst_ni & ~ce_ni & strobe_ok;
  assign cs_no  = enable ? ~hit_i : '1;
endmodule

// File: rtl/hiaddr_latch_dec.sv
`timescale 1ns/1ps
module hiaddr_latch_dec
  import hiaddr_latch_dec_pkg::*;
#(
  parameter int unsigned  HI_W      = 4,
  parameter int unsigned  SEL_W     = 2,
  parameter gate_mode_e   GATE_MODE = GATE_CE_RW,
  localparam int unsigned MA_W      = HI_W + SEL_W,
  localparam int unsigned NUM_CS    = 1 << SEL_W
) (
  input  logic              rst_ni,
  input  logic              stb_i,
  input  logic              ce_ni,
  input  logic              rd_ni,
  input  logic              wr_ni,
  input  logic [MA_W-1:0]   ma_i,
  output logic [HI_W-1:0]   hi_addr_o,
  output logic [NUM_CS-1:0] cs_no
);
  logic [MA_W-1:0]   ma_q;
  logic [NUM_CS-1:0] hit;

  // Raw select bits are held, not the one-hot: 2 storage bits instead of 4.
  had_latch #(.W(MA_W)) u_latch (
    .rst_ni (rst_ni),
    .en_i   (stb_i),
    .d_i    (ma_i),
    .q_o    (ma_q)
  );

  assign hi_addr_o = ma_q[HI_W-1:0];

  had_sel_decode #(.SEL_W(SEL_W)) u_dec (
    .sel_i (ma_q[MA_W-1:HI_W]),
    .hit_o (hit)
  );

  had_cs_gate #(.N(NUM_CS), .GATE_MODE(GATE_MODE)) u_gate (
    .rst_ni (rst_ni),
    .ce_ni  (ce_ni),
    .rd_ni  (rd_ni),
    .wr_ni  (wr_ni),
    .hit_i  (hit),
    .cs_no  (cs_no)
  );
endmodule

// File: rtl/hiaddr_latch_dec_chk.sv
`timescale 1ns/1ps
module hiaddr_latch_dec_chk
  import hiaddr_latch_dec_pkg::*;
#(
  parameter int unsigned  HI_W      = 4,
  parameter int unsigned  SEL_W     = 2,
  parameter gate_mode_e   GATE_MODE = GATE_CE_RW,
  localparam int unsigned MA_W      = HI_W + SEL_W,
  localparam int unsigned NUM_CS    = 1 << SEL_W
) (
  input logic              rst_ni,
  input logic              stb_i,
  input logic              ce_ni,
  input logic              rd_ni,
  input logic              wr_ni,
  input logic [MA_W-1:0]   ma_i,
  input logic [HI_W-1:0]   hi_addr_o,
  input logic [NUM_CS-1:0] cs_no
);
  logic gate_open;
  assign gate_open = (GATE_MODE == GATE_CE_ONLY) || !(rd_ni && wr_ni);

  always_comb begin
    if (!rst_ni) begin
      a_r8_reset_idle: assert (hi_addr_o == '0 && cs_no == '1);
    end
    if (rst_ni && stb_i) begin
      a_r1_follow: assert (hi_addr_o == ma_i[HI_W-1:0]);
    end
    if (rst_ni && ce_ni) begin
      a_r4_ce_blocks: assert (cs_no == '1);
    end
    if (rst_ni && !gate_open) begin
      a_r5_rw_gate: assert (cs_no == '1);
    end
    if (rst_ni && !ce_ni && gate_open) begin
      a_r3_one_select: assert ($countones(~cs_no) == 1);
    end
  end
endmodule

bind hiaddr_latch_dec hiaddr_latch_dec_chk #(
  .HI_W(HI_W), .SEL_W(SEL_W), .GATE_MODE(GATE_MODE)
) u_chk (
  .rst_ni(rst_ni), .stb_i(stb_i), .ce_ni(ce_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
  .ma_i(ma_i), .hi_addr_o(hi_addr_o), .cs_no(cs_no)
);

// File: tb/hiaddr_latch_dec_bench.sv
`timescale 1ns/1ps
module hiaddr_latch_dec_bench;
  import hiaddr_latch_dec_pkg::*;

  typedef struct {
    logic [3:0] hi;
    logic [3:0] cs_g;
    logic [3:0] cs_p;
    string      tag;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0, stb_i = 1'b0, ce_ni = 1'b0, rd_ni = 1'b1, wr_ni = 1'b1;
  logic [5:0] ma_i = '0;
  logic [3:0] hi_g, hi_p, cs_g, cs_p;

  item_t      q[$];
  logic [5:0] held = '0;
  int         total = 0, bad = 0, cycles = 0;
  bit         done = 0, finished = 0;

  always #10 clk = ~clk;

  hiaddr_latch_dec #(.GATE_MODE(GATE_CE_RW)) u_hiaddr_latch_dec (
    .rst_ni(rst_ni), .stb_i(stb_i), .ce_ni(ce_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .ma_i(ma_i), .hi_addr_o(hi_g), .cs_no(cs_g)
  );

  hiaddr_latch_dec #(.GATE_MODE(GATE_CE_ONLY)) u_hiaddr_latch_dec_plain (
    .rst_ni(rst_ni), .stb_i(stb_i), .ce_ni(ce_ni), .rd_ni(rd_ni), .wr_ni(wr_ni),
    .ma_i(ma_i), .hi_addr_o(hi_p), .cs_no(cs_p)
  );

  // Driver: apply one vector and push the model's expectation.
  task automatic drive(input logic r, input logic s, input logic ce, input logic rd,
                       input logic wr, input logic [5:0] a, input string tag);
    item_t it;
    logic [3:0] onehot_n;
    @(posedge clk);
    rst_ni = r; stb_i = s; ce_ni = ce; rd_ni = rd; wr_ni = wr; ma_i = a;
    if (!r) held = '0;
    else if (s) held = a;
    onehot_n = ~(4'b0001 << held[5:4]);
    it.hi   = held[3:0];
    it.cs_p = (r && !ce) ? onehot_n : 4'hF;
    it.cs_g = (r && !ce && !(rd && wr)) ? onehot_n : 4'hF;
    it.tag  = tag;
    q.push_back(it);
  endtask

  // Monitor: compare away from the driving edge.
  always @(negedge clk) begin
    if (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      total += 4;
      if (hi_g !== it.hi) begin
        bad++; $display("FAIL %s R2 gated hi_addr act=%h exp=%h", it.tag, hi_g, it.hi);
      end
      if (hi_p !== it.hi) begin
        bad++; $display("FAIL %s R2 plain hi_addr act=%h exp=%h", it.tag, hi_p, it.hi);
      end
      if (cs_g !== it.cs_g) begin
        bad++; $display("FAIL %s R5 gated cs act=%b exp=%b", it.tag, cs_g, it.cs_g);
      end
      if (cs_p !== it.cs_p) begin
        bad++; $display("FAIL %s R7 plain cs act=%b exp=%b", it.tag, cs_p, it.cs_p);
      end
    end
  end

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  initial begin
    // R8: reset holds zero even with the strobe open
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 6'h2A, "R8");
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, "R8");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b1, 6'h3F, "R8 release");
    // R1 / R3: transparent sweep of every address
    for (int a = 0; a < 64; a++) drive(1'b1, 1'b1, 1'b0, 1'b0, 1'b1, 6'(a), "R1 R3");
    // R6: hold each address while the bus moves away
    for (int a = 0; a < 64; a++) begin
      drive(1'b1, 1'b1, 1'b0, 1'b1, 1'b0, 6'(a), "R1");
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'(a), "R6");
      drive(1'b1, 1'b0, 1'b0, 1'b1, 1'b0, 6'(a) ^ 6'h3F, "R6");
      // R9 / R5 / R7: gating changes during hold
      for (int rw = 0; rw < 8; rw++)
        drive(1'b1, 1'b0, rw[2], rw[1], rw[0], 6'(a) ^ 6'h15, "R9 R5 R7");
    end
    // R4: enable high blocks selects in transparent mode; R2 unaffected
    for (int a = 0; a < 64; a += 3)
      for (int rw = 0; rw < 4; rw++)
        drive(1'b1, 1'b1, 1'b1, rw[1], rw[0], 6'(a), "R4 R2");
    // R8: reset again in mid-operation
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 6'h31, "R8");
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 6'h31, "R8");
    repeat (3) @(posedge clk);
    done = 1;
    finish_run();
  end

  initial begin
    while (!done) begin
      @(posedge clk);
      cycles++;
      if (cycles > 20000) begin
        total++; bad++;
        $display("FAIL watchdog expired act=%0d exp<=20000 cycles", cycles);
        finish_run();
      end
    end
  end
endmodule